// File: doc/BRIEF.md
# Branch Trace Packet Recorder

The recorder watches a processor core for changes in the program counter that do not follow straight-line flow: taken branches, exception entry, PC writes made from debug state, and exception returns. Each such change becomes a two-word packet that is written into a trace memory through a plain synchronous write port. The first word of a packet holds where the flow left from. The second word holds where it went to. Instruction addresses are halfword aligned, so bit 0 of each word is free and carries a status flag.

Bit 0 of the source word tells an ordinary instruction (0) apart from an exception entry or a debug PC write (1). Bit 0 of the destination word marks the first packet recorded after tracing is switched on. An exception return expands into two linked packets. The first goes from the returning instruction to the return code. The second goes from the return code to the resume address. The write pointer counts words and wraps around a power-of-two buffer. An event that arrives while a packet is still being written waits in a single pending slot.

Top module: `branch_trace_recorder`

## Requirements
- R1: After reset `mem_we` is 0 and the first packet recorded is written at word address 0.
- R2: An accepted taken branch writes `{pc_cur[31:1], A}` at an even word address in the cycle after the accepting clock edge, then `{pc_next[31:1], S}` at the next odd address in the following cycle, with A = 0.
- R3: For `exc_entry` or `dbg_pc_wr`, bit 0 of the source word (A) is 1. The source field is `pc_cur`, which the core presents as the preferred return address, and the destination field is `pc_next`.
- R4: Bit 0 of the destination word (S) is 1 only on the first packet of the first event accepted after reset or after `trace_en` has been low. It is 0 on every other packet.
- R5: `exc_ret` produces two consecutive packets. The first is source `pc_cur`, destination `exc_ret_val`, A = 0. The second is source `exc_ret_val`, destination `exc_resume`, A = 1, S = 0.
- R6: When several strobes are high in one cycle, one event is taken with priority `exc_ret` > `exc_entry` > `dbg_pc_wr` > `br_taken`.
- R7: The word pointer advances by 2 per packet and wraps modulo `DEPTH_WORDS`. A packet is never split across the wrap.
- R8: Strobes seen while `trace_en` is 0 are dropped and cause no memory write.
- R9: An event that arrives while a packet is being written is held in one pending slot. It is written after the current packet, and after the second packet of an exception return if one is queued. An event that finds the pending slot full and cannot be loaded in that cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trace_en | input | 1 | Trace enable; low drops events and re-arms the start flag |
| pc_cur | input | 32 | Source address of the current change (preferred return address on exception entry) |
| pc_next | input | 32 | Destination address of the current change |
| br_taken | input | 1 | Taken-branch strobe |
| exc_entry | input | 1 | Exception-entry strobe |
| dbg_pc_wr | input | 1 | PC written from debug state |
| exc_ret | input | 1 | Exception-return strobe |
| exc_ret_val | input | 32 | Exception-return code |
| exc_resume | input | 32 | Address where execution resumes after the return |
| mem_we | output | 1 | Trace memory write enable |
| mem_addr | output | $clog2(DEPTH_WORDS) | Trace memory word address |
| mem_wdata | output | 32 | Trace memory write data |

## Verification
Single events are spaced far apart, which isolates how each event kind is encoded: branch against exception entry against debug write in the A flag, and the two-packet shape of a return. Strobes raised together separate the priority levels from one another. Bursts of events on consecutive cycles, with and without an exception return at their head, separate the pending slot from the drop path and show the order of writes. Toggling `trace_en` and running past the end of the buffer show the start flag re-arming and the pointer wrapping.

// File: rtl/btr_pkg.sv
`timescale 1ns/1ps
package btr_pkg;

  typedef enum logic [1:0] {
    EV_BRANCH = 2'd0,
    EV_EXC    = 2'd1,
    EV_DBG    = 2'd2,
    EV_RET    = 2'd3
  } ev_kind_e;

  // One captured flow change; aux is used only by exception return
  typedef struct packed {
    ev_kind_e    kind;
    logic        s;
    logic [31:0] src;
    logic [31:0] dst;
    logic [31:0] aux;
  } ev_t;

  typedef struct packed {
    logic [31:0] w_src;
    logic [31:0] w_dst;
  } pkt_t;

  function automatic logic [31:0] pack_addr(logic [31:0] addr, logic flag);
    return {addr[31:1], flag};
  endfunction

  function automatic logic async_origin(ev_kind_e k);
    return (k == EV_EXC) || (k == EV_DBG);
  endfunction

  function automatic pkt_t first_pkt(ev_t e);
    pkt_t p;
    p.w_src = pack_addr(e.src, async_origin(e.kind));
    p.w_dst = pack_addr(e.dst, e.s);
    return p;
  endfunction

  // Second half of an exception return: return code -> resume point
  function automatic pkt_t second_pkt(ev_t e);
    pkt_t p;
    p.w_src = pack_addr(e.dst, 1'b1);
    p.w_dst = pack_addr(e.aux, 1'b0);
    return p;
  endfunction

endpackage

// File: rtl/btr_event_sel.sv
`timescale 1ns/1ps
module btr_event_sel
  import btr_pkg::*;
(
  input  logic        trace_en,
  input  logic        s_arm,
  input  logic [31:0] pc_cur,
  input  logic [31:0] pc_next,
  input  logic        br_taken,
  input  logic        exc_entry,
  input  logic        dbg_pc_wr,
  input  logic        exc_ret,
  input  logic [31:0] exc_ret_val,
  input  logic [31:0] exc_resume,
  output logic        ev_v,
  output ev_t         ev
);

  logic any_strobe;
  assign any_strobe = br_taken | exc_entry | dbg_pc_wr | exc_ret;
  assign ev_v       = trace_en & any_strobe;

  // Fixed priority: return, exception entry, debug write, branch
  always_comb begin
    ev.s   = s_arm;
    ev.src = pc_cur;
    ev.dst = pc_next;
    ev.aux = 32'h0;
    if (exc_ret) begin
      ev.kind = EV_RET;
      ev.dst  = exc_ret_val;
      ev.aux  = exc_resume;
    end else if (exc_entry) begin
      ev.kind = EV_EXC;
    end else if (dbg_pc_wr) begin
      ev.kind = EV_DBG;
    end else begin
      ev.kind = EV_BRANCH;
    end
  end

endmodule

// File: rtl/btr_seq.sv
`timescale 1ns/1ps
module btr_seq
  import btr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        trace_en,
  input  logic        ev_v,
  input  ev_t         ev_in,
  output logic        s_arm,
  output logic        busy,
  output logic        phase,
  output logic        done,
  output logic [31:0] word
);

  logic busy_q, phase_q, sec_v_q, pend_v_q, s_arm_q;
  pkt_t cur_q, sec_q;
  ev_t  pend_q;

  // Named internal events
  logic free, ld_sec, ld_pend, ld_new, st_pend, ld_any, ld_ret, keep;
  ev_t  ld_ev;

  assign free    = !busy_q || phase_q;
  assign ld_sec  = free && sec_v_q;
  assign ld_pend = free && !sec_v_q && pend_v_q;
  assign ld_new  = free && !sec_v_q && !pend_v_q && ev_v;
  assign st_pend = ev_v && !ld_new && (!pend_v_q || ld_pend);
  assign keep    = ld_new || st_pend;
  assign ld_any  = ld_sec || ld_pend || ld_new;
  assign ld_ev   = ld_pend ? pend_q : ev_in;
  assign ld_ret  = (ld_pend || ld_new) && (ld_ev.kind == EV_RET);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      phase_q  <= 1'b0;
      sec_v_q  <= 1'b0;
      pend_v_q <= 1'b0;
      s_arm_q  <= 1'b1;
      cur_q    <= '0;
      sec_q    <= '0;
      pend_q   <= '0;
    end else begin
      if (ld_any) begin
        busy_q  <= 1'b1;
        phase_q <= 1'b0;
        cur_q   <= ld_sec ? sec_q : first_pkt(ld_ev);
      end else if (busy_q && phase_q) begin
        busy_q  <= 1'b0;
        phase_q <= 1'b0;
      end else if (busy_q) begin
        phase_q <= 1'b1;
      end

      if (ld_sec)      sec_v_q <= 1'b0;
      else if (ld_ret) sec_v_q <= 1'b1;
      if (ld_ret)      sec_q   <= second_pkt(ld_ev);

      if (st_pend)      pend_v_q <= 1'b1;
      else if (ld_pend) pend_v_q <= 1'b0;
      if (st_pend)      pend_q   <= ev_in;

      if (!trace_en)   s_arm_q <= 1'b1;
      else if (keep)   s_arm_q <= 1'b0;
    end
  end

  assign s_arm = s_arm_q;
  assign busy  = busy_q;
  assign phase = phase_q;
  assign done  = busy_q && phase_q;
  assign word  = phase_q ? cur_q.w_dst : cur_q.w_src;

  // R2
  src_dst_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !phase_q) |=> (busy_q && phase_q));

  // R3
  exc_a_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ld_new || ld_pend) && async_origin(ld_ev.kind)) |=> word[0]);

  // R5
  ret_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ret |=> ##2 (busy_q && !phase_q && word[0]));

  // R9
  pend_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_v_q |-> busy_q);

  // R8
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!trace_en && !busy_q && !pend_v_q && !sec_v_q) |=> !busy_q);

endmodule

// File: rtl/btr_ptr.sv
`timescale 1ns/1ps
module btr_ptr #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [AW-1:0] ptr
);

  localparam logic [AW-1:0] STEP = AW'(2);

  function automatic logic [AW-1:0] next_ptr(logic [AW-1:0] p);
    return p + STEP;
  endfunction

  logic [AW-1:0] ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr_q <= '0;
    else if (adv) ptr_q <= next_ptr(ptr_q);
  end

  assign ptr = ptr_q;

  // R7
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (ptr_q == $past(ptr_q) + STEP));

  // R7
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(ptr_q));

endmodule

// File: rtl/branch_trace_recorder.sv
`timescale 1ns/1ps
module branch_trace_recorder
  import btr_pkg::*;
#(
  parameter int DEPTH_WORDS = 64,
  localparam int AW = $clog2(DEPTH_WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trace_en,
  input  logic [31:0]   pc_cur,
  input  logic [31:0]   pc_next,
  input  logic          br_taken,
  input  logic          exc_entry,
  input  logic          dbg_pc_wr,
  input  logic          exc_ret,
  input  logic [31:0]   exc_ret_val,
  input  logic [31:0]   exc_resume,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata
);

  logic          ev_v, s_arm, busy, phase, done;
  ev_t           ev;
  logic [31:0]   word;
  logic [AW-1:0] ptr;

  btr_event_sel u_sel (
    .trace_en    (trace_en),
    .s_arm       (s_arm),
    .pc_cur      (pc_cur),
    .pc_next     (pc_next),
    .br_taken    (br_taken),
    .exc_entry   (exc_entry),
    .dbg_pc_wr   (dbg_pc_wr),
    .exc_ret     (exc_ret),
    .exc_ret_val (exc_ret_val),
    .exc_resume  (exc_resume),
    .ev_v        (ev_v),
    .ev          (ev)
  );

  btr_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .trace_en (trace_en),
    .ev_v     (ev_v),
    .ev_in    (ev),
    .s_arm    (s_arm),
    .busy     (busy),
    .phase    (phase),
    .done     (done),
    .word     (word)
  );

  btr_ptr #(.AW(AW)) u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (done),
    .ptr   (ptr)
  );

  assign mem_we    = busy;
  assign mem_addr  = ptr | AW'(phase);
  assign mem_wdata = word;

  // R2
  odd_follows_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !mem_addr[0]) |=> (mem_we && mem_addr == $past(mem_addr) + AW'(1)));

endmodule

// File: tb/sim_branch_trace_recorder.sv
`timescale 1ns/1ps
module sim_branch_trace_recorder;

  localparam int DEPTH = 16;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0, rst_n = 1'b0, trace_en = 1'b0;
  logic [31:0] pc_cur = '0, pc_next = '0, exc_ret_val = '0, exc_resume = '0;
  logic br_taken = 0, exc_entry = 0, dbg_pc_wr = 0, exc_ret = 0;
  logic mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata;

  always #2.5 clk = ~clk;

  branch_trace_recorder #(.DEPTH_WORDS(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .trace_en(trace_en),
    .pc_cur(pc_cur), .pc_next(pc_next),
    .br_taken(br_taken), .exc_entry(exc_entry), .dbg_pc_wr(dbg_pc_wr),
    .exc_ret(exc_ret), .exc_ret_val(exc_ret_val), .exc_resume(exc_resume),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  int checks = 0, fails = 0;
  bit finished = 0;
  string cur_req = "R1";
  int exp_ptr = 0;
  bit s_arm = 1;
  int q_addr[$];
  logic [31:0] q_data[$];

  task automatic push_pkt(logic [31:0] s, logic [31:0] d, bit a, bit sf);
    q_addr.push_back(exp_ptr);
    q_data.push_back({s[31:1], a});
    q_addr.push_back(exp_ptr + 1);
    q_data.push_back({d[31:1], sf});
    exp_ptr = (exp_ptr + 2) % DEPTH;
  endtask

  // Driver: strobes {ret, exc, dbg, br} for one cycle; keep=0 means expected drop
  task automatic send(bit r, bit x, bit g, bit b, logic [31:0] pc, logic [31:0] nx,
                      logic [31:0] rv, logic [31:0] rs, bit keep);
    bit sf;
    @(negedge clk);
    exc_ret = r; exc_entry = x; dbg_pc_wr = g; br_taken = b;
    pc_cur = pc; pc_next = nx; exc_ret_val = rv; exc_resume = rs;
    if (keep && trace_en && (r | x | g | b)) begin
      sf = s_arm;
      s_arm = 0;
      if (r) begin
        push_pkt(pc, rv, 1'b0, sf);
        push_pkt(rv, rs, 1'b1, 1'b0);
      end else if (x || g) begin
        push_pkt(pc, nx, 1'b1, sf);
      end else begin
        push_pkt(pc, nx, 1'b0, sf);
      end
    end
  endtask

  task automatic idle();
    @(negedge clk);
    exc_ret = 0; exc_entry = 0; dbg_pc_wr = 0; br_taken = 0;
  endtask

  task automatic drain();
    for (int i = 0; i < 40 && q_addr.size() != 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    checks++;
    if (q_addr.size() != 0) begin
      fails++;
      $display("FAIL %s: %0d writes missing, expected 0", cur_req, q_addr.size());
      q_addr.delete();
      q_data.delete();
    end
  endtask

  // Monitor: pops expected writes and compares away from the active edge
  always @(negedge clk) begin
    if (rst_n && mem_we && !finished) begin
      checks++;
      if (q_addr.size() == 0) begin
        fails++;
        $display("FAIL %s: unexpected write addr=%0d data=%h, expected none",
                 cur_req, mem_addr, mem_wdata);
      end else begin
        int ea;
        logic [31:0] ed;
        ea = q_addr.pop_front();
        ed = q_data.pop_front();
        if (int'(mem_addr) != ea || mem_wdata !== ed) begin
          fails++;
          $display("FAIL %s: addr=%0d data=%h, expected addr=%0d data=%h",
                   cur_req, mem_addr, mem_wdata, ea, ed);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  [TB] %0d tests run, %0d failed", checks + 1, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (mem_we !== 1'b0) begin
      fails++;
      $display("FAIL R1: mem_we=%b during reset, expected 0", mem_we);
    end
    rst_n = 1;
    @(negedge clk);
    checks++;
    if (mem_we !== 1'b0) begin
      fails++;
      $display("FAIL R1: mem_we=%b after reset, expected 0", mem_we);
    end
    trace_en = 1;

    // R1 R2 R4: first branch at word 0 with S=1; second with S=0; bit 0 masked
    cur_req = "R2";
    send(0,0,0,1, 32'h0000_1235, 32'h0000_4001, 0, 0, 1); idle(); drain();
    send(0,0,0,1, 32'h0000_2000, 32'h0000_3002, 0, 0, 1); idle(); drain();

    // R3: exception entry and debug write set A
    cur_req = "R3";
    send(0,1,0,0, 32'h0000_5556, 32'h0000_0040, 0, 0, 1); idle(); drain();
    send(0,0,1,0, 32'h0000_6000, 32'h0000_7777, 0, 0, 1); idle(); drain();

    // R5: exception return expands into two packets
    cur_req = "R5";
    send(0,0,0,0, 0, 0, 0, 0, 1);
    send(1,0,0,0, 32'h0000_8010, 32'h0, 32'hFFFF_FFF9, 32'h0000_9124, 1); idle(); drain();

    // R6: priority among simultaneous strobes
    cur_req = "R6";
    send(1,1,1,1, 32'h0000_A000, 32'h0000_A100, 32'hFFFF_FFF1, 32'h0000_A200, 1); idle(); drain();
    send(0,1,1,1, 32'h0000_B000, 32'h0000_B100, 0, 0, 1); idle(); drain();
    send(0,0,1,1, 32'h0000_C000, 32'h0000_C100, 0, 0, 1); idle(); drain();

    // R9: burst of five branches -> fourth dropped
    cur_req = "R9";
    send(0,0,0,1, 32'h0001_0000, 32'h0001_0100, 0, 0, 1);
    send(0,0,0,1, 32'h0001_1000, 32'h0001_1100, 0, 0, 1);
    send(0,0,0,1, 32'h0001_2000, 32'h0001_2100, 0, 0, 1);
    send(0,0,0,1, 32'h0001_3000, 32'h0001_3100, 0, 0, 0);
    send(0,0,0,1, 32'h0001_4000, 32'h0001_4100, 0, 0, 1);
    idle(); drain();
    // R9: return then two branches -> pending held past second packet, third dropped
    send(1,0,0,0, 32'h0002_0000, 0, 32'hFFFF_FFFD, 32'h0002_0400, 1);
    send(0,0,0,1, 32'h0002_1000, 32'h0002_1100, 0, 0, 1);
    send(0,0,0,1, 32'h0002_2000, 32'h0002_2100, 0, 0, 0);
    idle(); drain();

    // R8: disabled events produce no writes
    cur_req = "R8";
    @(negedge clk); trace_en = 0; s_arm = 1;
    send(0,0,0,1, 32'h0003_0000, 32'h0003_0100, 0, 0, 1);
    send(1,1,0,0, 32'h0003_1000, 32'h0003_1100, 32'hFFFF_FFF9, 32'h0003_2000, 1);
    idle(); drain();
    // R4: S re-armed after enable returns high
    cur_req = "R4";
    @(negedge clk); trace_en = 1;
    send(0,0,0,1, 32'h0004_0000, 32'h0004_0100, 0, 0, 1); idle(); drain();
    send(0,0,0,1, 32'h0004_1000, 32'h0004_1100, 0, 0, 1); idle(); drain();

    // R7: run past the buffer end so the pointer wraps
    cur_req = "R7";
    for (int k = 0; k < 10; k++) begin
      send(0,0,0,1, 32'h0005_0000 + k * 16, 32'h0006_0000 + k * 16, 0, 0, 1);
      idle(); drain();
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule